// File: doc/BRIEF.md
# SPI memory slave front end

This block is the serial-side front end of a byte-wide memory that sits on an SPI bus as a slave. It works in a fast system clock domain and treats the bus lines (serial clock, active-low select, serial input and active-low hold) as asynchronous inputs. Each line passes through a synchronizer, and the block then detects serial clock edges from the synchronized copy. Both idle-clock polarities that sample on the rising edge are accepted: clock idle low (mode 0) and clock idle high (mode 3).

After the select line falls, the first byte is taken as a command. Six opcode values are recognized, each set by a parameter: read, write, write-enable, write-disable, status read and status write. Read and write commands are followed by a 16-bit address. The block turns the serial stream into single-cycle strobes on a parallel back-end port. It asks for read bytes one at a time and shifts them out on the serial output, advancing the address after each byte. An unknown opcode makes the block ignore the bus until the select line is released and asserted again. The hold input freezes a transfer in place so that it can resume at the same bit.

The serial clock must stay high and low for at least six system clocks each. This covers synchronizer latency and the two-cycle read fetch.

Top module: `spi_mem_front`

## Requirements
- R1: While cs_ni is high, so_oe_o is 0 and no back-end strobe fires. After reset, so_oe_o and all strobes are 0.
- R2: si_i is sampled on rising sck_i edges, most significant bit first. The first eight bits after cs_ni falls form the opcode. Defaults: read 0x03, write 0x02, write-enable 0x06, write-disable 0x04, status read 0x05, status write 0x01.
- R3: Any other opcode value locks the block out. No strobe fires and so_oe_o stays 0 for the rest of the selection. The next selection decodes normally.
- R4: A write-enable or write-disable opcode gives a one-cycle pulse on wren_stb_o or wrdi_stb_o. Later bits in the same selection are ignored.
- R5: A read opcode takes two address bytes, high byte first. The block then pulses rd_stb_o with addr_o, samples rdata_i on the next clock, and shifts that byte out on so_o MSB first. so_o changes on falling sck_i, and so_oe_o is 1 from the first falling edge after the address.
- R6: During a read, each completed output byte advances the address by one and issues a new rd_stb_o. The address wraps from 0xFFFF to 0x0000.
- R7: A write opcode takes two address bytes. Each completed data byte then pulses wr_stb_o with addr_o and wdata_o, and the address advances by one afterwards.
- R8: A status read shifts status_i out repeatedly for as long as the select line stays low. A status write pulses wrsr_stb_o once, with the first data byte on wdata_o. Later bytes are ignored.
- R9: Raising cs_ni partway through a byte drops the partial bits and fires no strobe. The next selection starts at bit 0 of a new opcode.
- R10: A low hold_ni takes effect only while sck_i is low, and a high hold_ni releases only while sck_i is low. While held, sck_i edges and si_i are ignored and so_oe_o is 0. The bit position is kept, so a held read continues with correct data.
- R11: Reads, writes and commands behave the same in mode 0 and mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock (asynchronous) |
| cs_ni | input | 1 | Active-low select (asynchronous) |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Active-low pause |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o; 0 means high impedance |
| addr_o | output | 16 | Back-end byte address |
| rd_stb_o | output | 1 | Read request, one cycle |
| rdata_i | input | 8 | Read byte, valid the cycle after rd_stb_o |
| wr_stb_o | output | 1 | Write request, one cycle |
| wdata_o | output | 8 | Write byte for wr_stb_o and wrsr_stb_o |
| wren_stb_o | output | 1 | Write-enable command pulse |
| wrdi_stb_o | output | 1 | Write-disable command pulse |
| wrsr_stb_o | output | 1 | Status write pulse |
| status_i | input | 8 | Status byte to shift out |

## Verification
Reads are tried in both clock polarities, from an ordinary address and from 0xFFFE, so that wrap is told apart from plain increment. A hold is inserted mid-byte with the clock toggling, which shows whether the bit position survives. Multi-byte writes, every command opcode, status access and an unknown opcode followed by write-like traffic separate correct decode from lockout leakage. Selections cut off in the opcode and in the data phase show whether partial bits are discarded; each is followed by a clean command whose strobe must appear.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDAT, ST_WDAT, ST_SRD, ST_SWR, ST_SKIP, ST_LOCK
  } st_e;

  typedef enum logic {AC_RD, AC_WR} acc_e;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int unsigned W = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [W-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= g_stg[s-1].q;
    end
  end

  assign q_o = g_stg[STAGES-1].q;
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
  parameter int unsigned DW = 8,
  localparam int unsigned CW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [DW-1:0] byte_o,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);
  logic [DW-2:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == CW'(DW-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[DW-3:0], bit_i};
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign byte_o = {sh_q, bit_i};
  assign done_o = shift_i & last;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          shift_i,
  output logic          bit_o
);
  logic [DW-1:0] sh_q;
  logic          bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_q <= 1'b0;
    end else if (load_i) begin
      sh_q <= data_i;
    end else if (shift_i) begin
      bit_q <= sh_q[DW-1];
      sh_q  <= {sh_q[DW-2:0], 1'b0};
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
  import spi_fe_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DW-1:0] OP_READ = 8'h03,
  parameter logic [DW-1:0] OP_WRITE = 8'h02,
  parameter logic [DW-1:0] OP_WREN = 8'h06,
  parameter logic [DW-1:0] OP_WRDI = 8'h04,
  parameter logic [DW-1:0] OP_RDSR = 8'h05,
  parameter logic [DW-1:0] OP_WRSR = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          cs_ni,
  input  logic          si_i,
  input  logic          hold_ni,
  output logic          so_o,
  output logic          so_oe_o,
  output logic [AW-1:0] addr_o,
  output logic          rd_stb_o,
  input  logic [DW-1:0] rdata_i,
  output logic          wr_stb_o,
  output logic [DW-1:0] wdata_o,
  output logic          wren_stb_o,
  output logic          wrdi_stb_o,
  output logic          wrsr_stb_o,
  input  logic [DW-1:0] status_i
);
  localparam int unsigned AB  = AW / DW;
  localparam int unsigned ABW = (AB > 1) ? $clog2(AB) : 1;
  localparam int unsigned CW  = $clog2(DW);

  // synchronized bus lines: {hold_n, si, cs_n, sck}
  logic [3:0] bus_s;
  logic sck_s, cs_s, si_s, hold_s;

  spi_fe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hold_ni, si_i, cs_ni, sck_i}),
    .q_o   (bus_s)
  );
  assign sck_s  = bus_s[0];
  assign cs_s   = bus_s[1];
  assign si_s   = bus_s[2];
  assign hold_s = bus_s[3];

  logic sck_q, rise, fall, cs_act, hold_act;
  st_e  st_q;
  acc_e acc_q;
  logic active, out_st, out_on;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s;

  assign rise   = sck_s & ~sck_q;
  assign fall   = ~sck_s & sck_q;
  assign cs_act = ~cs_s;

  // hold enters and leaves only while the serial clock is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hold_act <= 1'b0;
    else if (!cs_act)                hold_act <= 1'b0;
    else if (!hold_act)              hold_act <= ~hold_s & ~sck_s;
    else if (hold_s && !sck_s)       hold_act <= 1'b0;
  end

  assign active = cs_act & ~hold_act &
                  (st_q != ST_IDLE) & (st_q != ST_SKIP) & (st_q != ST_LOCK);
  assign out_st = (st_q == ST_RDAT) | (st_q == ST_SRD);

  logic [DW-1:0] rx_byte;
  logic          rx_done;
  logic [CW-1:0] rx_cnt;

  spi_fe_rx #(.DW(DW)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~cs_act),
    .shift_i(active & rise),
    .bit_i  (si_s),
    .byte_o (rx_byte),
    .done_o (rx_done),
    .cnt_o  (rx_cnt)
  );

  logic [AW-1:0]  addr_q;
  logic [ABW-1:0] ab_q;
  logic [DW-1:0]  wdata_q;
  logic rd_stb_q, wr_stb_q, wren_q, wrdi_q, wrsr_q, ld_q;
  logic stat_ld;

  assign stat_ld = rx_done & (((st_q == ST_OPC) & (rx_byte == OP_RDSR)) | (st_q == ST_SRD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      acc_q    <= AC_RD;
      addr_q   <= '0;
      ab_q     <= '0;
      wdata_q  <= '0;
      rd_stb_q <= 1'b0;
      wr_stb_q <= 1'b0;
      wren_q   <= 1'b0;
      wrdi_q   <= 1'b0;
      wrsr_q   <= 1'b0;
      ld_q     <= 1'b0;
    end else begin
      rd_stb_q <= 1'b0;
      wr_stb_q <= 1'b0;
      wren_q   <= 1'b0;
      wrdi_q   <= 1'b0;
      wrsr_q   <= 1'b0;
      ld_q     <= rd_stb_q;
      if (!cs_act) begin
        st_q <= ST_IDLE;
      end else if (rx_done) begin
        unique case (st_q)
          ST_OPC: begin
            ab_q <= '0;
            if (rx_byte == OP_READ) begin
              acc_q <= AC_RD;
              st_q  <= ST_ADDR;
            end else if (rx_byte == OP_WRITE) begin
              acc_q <= AC_WR;
              st_q  <= ST_ADDR;
            end else if (rx_byte == OP_WREN) begin
              wren_q <= 1'b1;
              st_q   <= ST_SKIP;
            end else if (rx_byte == OP_WRDI) begin
              wrdi_q <= 1'b1;
              st_q   <= ST_SKIP;
            end else if (rx_byte == OP_RDSR) begin
              st_q <= ST_SRD;
            end else if (rx_byte == OP_WRSR) begin
              st_q <= ST_SWR;
            end else begin
              st_q <= ST_LOCK;
            end
          end
          ST_ADDR: begin
            addr_q <= {addr_q[AW-DW-1:0], rx_byte};
            ab_q   <= ab_q + 1'b1;
            if (ab_q == ABW'(AB-1)) begin
              if (acc_q == AC_RD) begin
                st_q     <= ST_RDAT;
                rd_stb_q <= 1'b1;
              end else begin
                st_q <= ST_WDAT;
              end
            end
          end
          ST_RDAT: begin
            addr_q   <= addr_q + 1'b1;
            rd_stb_q <= 1'b1;
          end
          ST_WDAT: begin
            wr_stb_q <= 1'b1;
            wdata_q  <= rx_byte;
          end
          ST_SWR: begin
            wrsr_q  <= 1'b1;
            wdata_q <= rx_byte;
            st_q    <= ST_SKIP;
          end
          default: ;
        endcase
      end else if (st_q == ST_IDLE) begin
        st_q <= ST_OPC;
      end
      // write address advances once the strobe has been presented
      if (wr_stb_q) addr_q <= addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  out_on <= 1'b0;
    else if (!cs_act)             out_on <= 1'b0;
    else if (active && fall && out_st) out_on <= 1'b1;
  end

  spi_fe_tx #(.DW(DW)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld_q | stat_ld),
    .data_i (ld_q ? rdata_i : status_i),
    .shift_i(active & fall & out_st),
    .bit_o  (so_o)
  );

  assign so_oe_o    = out_on & cs_act & ~hold_act & out_st;
  assign addr_o     = addr_q;
  assign rd_stb_o   = rd_stb_q;
  assign wr_stb_o   = wr_stb_q;
  assign wdata_o    = wdata_q;
  assign wren_stb_o = wren_q;
  assign wrdi_stb_o = wrdi_q;
  assign wrsr_stb_o = wrsr_q;

  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> !so_oe_o && !rd_stb_o && !wr_stb_o && !wrsr_stb_o); // R1
  AST_LOCK_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOCK) |-> !so_oe_o && !rd_stb_o && !wr_stb_o && !wrsr_stb_o
                          && !wren_stb_o && !wrdi_stb_o); // R3
  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o); // R7
  AST_WR_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> addr_o == $past(addr_o) + 1'b1); // R7
  AST_RD_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act && st_q == ST_RDAT && rx_done) |=> rd_stb_o && addr_o == $past(addr_o) + 1'b1); // R6
  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_act && $past(hold_act) && $past(cs_act)) |-> $stable(rx_cnt)); // R10
endmodule

// File: tb/spi_mem_front_tb.sv
module spi_mem_front_tb;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic [7:0] status = 8'hC3;
  logic so, so_oe, rd_stb, wr_stb, wren_stb, wrdi_stb, wrsr_stb;
  logic [15:0] addr;
  logic [7:0] wdata, rdata;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_fn(logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
  endfunction
  assign rdata = mem_fn(addr);

  spi_mem_front u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si), .hold_ni(hold_n),
    .so_o(so), .so_oe_o(so_oe), .addr_o(addr), .rd_stb_o(rd_stb), .rdata_i(rdata),
    .wr_stb_o(wr_stb), .wdata_o(wdata), .wren_stb_o(wren_stb), .wrdi_stb_o(wrdi_stb),
    .wrsr_stb_o(wrsr_stb), .status_i(status)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0, quiet = 0, mode3 = 0;
  int cs_hi = 0;

  typedef struct { int kind; int a; int d; } ev_t;  // 0 rd,1 wr,2 wren,3 wrdi,4 wrsr
  ev_t exp_q[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int k);
    case (k)
      0: return "R5"; 1: return "R7"; 4: return "R8"; default: return "R4";
    endcase
  endfunction

  task automatic match(int k, int a, int d);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(0, req_of(k), "unexpected strobe kind", k, -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == k, req_of(e.kind), "strobe kind", k, e.kind);
      if (k == 0 || k == 1) chk(e.a == a, req_of(k), "strobe addr", a, e.a);
      if (k == 1 || k == 4) chk(e.d == d, req_of(k), "strobe data", d, e.d);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) if (rst_n && !done) begin
    if (rd_stb)   match(0, int'(addr), 0);
    if (wr_stb)   match(1, int'(addr), int'(wdata));
    if (wren_stb) match(2, 0, 0);
    if (wrdi_stb) match(3, 0, 0);
    if (wrsr_stb) match(4, 0, int'(wdata));
    cs_hi = cs_n ? cs_hi + 1 : 0;
    if (cs_hi >= 4) chk(!so_oe, "R1", "so_oe while deselected", so_oe, 0);
    if (quiet) chk(!so_oe, "R3", "so_oe while locked", so_oe, 0);
  end

  task automatic wclk(int n); repeat (n) @(negedge clk); endtask

  task automatic push(int k, int a, int d);
    ev_t e; e.kind = k; e.a = a & 16'hFFFF; e.d = d; exp_q.push_back(e);
  endtask

  task automatic do_hold();
    hold_n = 1'b0; wclk(H);
    for (int j = 0; j < 3; j++) begin
      sck = 1'b1; si = ~si; wclk(H);
      chk(!so_oe, "R10", "so_oe during hold (sck high)", so_oe, 0);
      sck = 1'b0; wclk(H);
      chk(!so_oe, "R10", "so_oe during hold (sck low)", so_oe, 0);
    end
    hold_n = 1'b1; wclk(H);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at,
                      output logic [7:0] rx, output bit oe_all);
    oe_all = 1; rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sck = 1'b0; si = tx[i]; wclk(H);
      if (i == hold_at) do_hold();
      rx[i] = so; if (!so_oe) oe_all = 0;
      sck = 1'b1; wclk(H);
    end
  endtask

  task automatic begin_tx(bit m3);
    mode3 = m3; sck = m3; wclk(H); cs_n = 1'b0; wclk(H);
  endtask

  task automatic end_tx(string req);
    if (!mode3) begin sck = 1'b0; wclk(H); end
    cs_n = 1'b1; wclk(3 * H);
    chk(exp_q.size() == 0, req, "pending strobes at end", exp_q.size(), 0);
  endtask

  task automatic send(logic [7:0] b);
    logic [7:0] r; bit o; xfer(b, 8, -1, r, o);
  endtask

  task automatic rd_txn(int a, int n, bit m3, int hold_byte, int hold_bit, string req);
    logic [7:0] r; bit o;
    for (int k = 0; k <= n; k++) push(0, a + k, 0);
    begin_tx(m3); send(8'h03); send(a[15:8]); send(a[7:0]);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, (k == hold_byte) ? hold_bit : -1, r, o);
      chk(r == mem_fn(16'(a + k)), req, "read data", r, mem_fn(16'(a + k)));
      chk(o, req, "so_oe during read", o, 1);
    end
    end_tx(req);
  endtask

  task automatic wr_txn(int a, logic [23:0] d, int n, bit m3, string req);
    for (int k = 0; k < n; k++) push(1, a + k, d[8*k +: 8]);
    begin_tx(m3); send(8'h02); send(a[15:8]); send(a[7:0]);
    for (int k = 0; k < n; k++) send(d[8*k +: 8]);
    end_tx(req);
  endtask

  task automatic cmd_txn(logic [7:0] op, int k, bit m3);
    push(k, 0, 0);
    begin_tx(m3); send(op); send(8'h02); send(8'h06); end_tx("R4");
  endtask

  initial begin
    logic [7:0] r; bit o;
    wclk(4); rst_n = 1'b1; wclk(4);
    chk(!so_oe, "R1", "so_oe after reset", so_oe, 0);
    chk(!(rd_stb | wr_stb | wren_stb | wrdi_stb | wrsr_stb), "R1", "strobes after reset", 0, 0);

    // R2 R5: mode 0 read of three bytes
    rd_txn(16'h1234, 3, 0, -1, -1, "R5");
    // R11: mode 3 read and write
    rd_txn(16'hA0F1, 2, 1, -1, -1, "R11");
    wr_txn(16'h4410, 24'hC3_5A_96, 3, 1, "R11");
    // R7: mode 0 write
    wr_txn(16'h00FF, 24'h00_7E_81, 2, 0, "R7");
    // R6: wrap at top of address space
    rd_txn(16'hFFFE, 3, 0, -1, -1, "R6");
    // R10: hold mid-byte in the second data byte
    rd_txn(16'h2222, 3, 0, 1, 4, "R10");
    // R4: commands, trailing bytes ignored
    cmd_txn(8'h06, 2, 0);
    cmd_txn(8'h04, 3, 1);

    // R8: status read twice, status write once
    begin_tx(0); send(8'h05);
    for (int k = 0; k < 2; k++) begin
      xfer(8'hFF, 8, -1, r, o);
      chk(r == status, "R8", "status byte", r, status);
      chk(o, "R8", "so_oe during status read", o, 1);
    end
    end_tx("R8");
    push(4, 0, 8'h9D);
    begin_tx(0); send(8'h01); send(8'h9D); send(8'h44); end_tx("R8");

    // R3: unknown opcode then write-looking traffic
    begin_tx(0); send(8'hA5); quiet = 1;
    send(8'h02); send(8'h00); xfer(8'h10, 8, -1, r, o); send(8'h11);
    chk(!o, "R3", "so_oe after bad opcode", o, 0);
    quiet = 0; end_tx("R3");
    cmd_txn(8'h06, 2, 0);

    // R9: abort mid opcode, then mid data byte
    begin_tx(0); xfer(8'h06, 4, -1, r, o); cs_n = 1'b1; wclk(3 * H);
    chk(exp_q.size() == 0, "R9", "events after opcode abort", exp_q.size(), 0);
    begin_tx(0); send(8'h02); send(8'h12); send(8'h34); xfer(8'hEE, 5, -1, r, o);
    cs_n = 1'b1; wclk(3 * H);
    chk(exp_q.size() == 0, "R9", "events after data abort", exp_q.size(), 0);
    cmd_txn(8'h04, 3, 0);
    wr_txn(16'h1234, 24'h0000AB, 1, 0, "R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule